// File: doc/BRIEF.md
# I2S Sample Packer

This block sits between a pair of byte-wide FIFOs and a codec-side sample interface. The transfer starts with one request carrying a transmit sample count and a receive sample count. For transmit, the block pops bytes from the transmit FIFO and packs them little-endian into samples of 1 to 4 bytes, then hands each sample to the codec over a valid/ready handshake. For receive, it takes samples from the codec over a second handshake, cuts each one into bytes, least significant byte first, and pushes them into the receive FIFO.

Each direction has a byte budget equal to its sample count times the sample width in bytes. If the transmit FIFO runs dry before the budget is spent, the block raises an underrun pulse. If the receive FIFO fills before the budget is spent, it raises an overrun pulse. The block does nothing unless the port is enabled and the frame format selects I2S. A busy flag covers the transfer. A one-cycle strobe then tells the surrounding logic to re-evaluate its FIFO threshold status. The transmit phase always completes before the receive phase starts. The block moves one byte per clock.

Top module: `i2s_sample_packer`

## Requirements
- R1: A request is taken only when `port_en` is 1 and `frame_fmt` equals 3 (I2S). A request offered while idle under any other setting is dropped: no busy, no strobe, no FIFO pop or push, no codec sample, no flag.
- R2: Transmit runs only when `tx_en` and `tx_oe` are both 1. Otherwise the transmit budget is zero, so no byte is popped, no sample is sent and no underrun is raised.
- R3: The sample width is `width_sel`+1 bytes (0 gives 1 byte, 3 gives 4 bytes). Each direction's budget is its request count times that width. At most that many bytes are popped or pushed per request, and `width_sel` is sampled when the request is taken.
- R4: Transmit byte i of a sample sits in bits 8i+7:8i of `cdc_tx_data`, and the first byte popped is the least significant. Unused upper bits are 0. If the FIFO empties partway through a sample, that partial sample is still presented, zero-padded.
- R5: `underrun_set` pulses for exactly one cycle in a transfer when the transmit FIFO is empty while transmit budget remains. It does not pulse when the budget runs out exactly as the FIFO empties.
- R6: Receive runs only when `rx_en` is 1. Each codec sample is split into bytes, least significant first. Bytes are pushed until the receive FIFO is full or the budget is spent, so the number pushed is the smaller of the budget and the free space.
- R7: `overrun_set` pulses for exactly one cycle in a transfer when the receive FIFO is full while receive budget remains. It does not pulse when the budget ends exactly at full.
- R8: `busy` is 1 from the cycle after a request is taken until the transfer ends. `eval_stb` pulses once, in the first cycle `busy` is 0 again. `req_ready` is 1 only when idle.
- R9: A transmit sample held with `cdc_tx_valid` and no `cdc_tx_ready` keeps its data stable. The block never pops transmit bytes and pushes receive bytes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable |
| frame_fmt | input | 3 | Frame format select, 3 = I2S |
| tx_en | input | 1 | Transmit enable |
| tx_oe | input | 1 | Transmit data output enable |
| rx_en | input | 1 | Receive enable |
| width_sel | input | 2 | Sample width in bytes minus one |
| req_valid | input | 1 | Codec asks for a transfer |
| req_tx_cnt | input | 8 | Transmit samples requested |
| req_rx_cnt | input | 8 | Receive samples requested |
| req_ready | output | 1 | Block is idle and takes a request |
| busy | output | 1 | Transfer in progress |
| eval_stb | output | 1 | Threshold re-evaluation strobe after a transfer |
| underrun_set | output | 1 | Transmit underrun pulse |
| overrun_set | output | 1 | Receive overrun pulse |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_rdata | input | 8 | Transmit FIFO head byte (show-ahead) |
| txf_pop | output | 1 | Pop the transmit FIFO head |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_wdata | output | 8 | Byte pushed to the receive FIFO |
| rxf_push | output | 1 | Push to the receive FIFO |
| cdc_tx_valid | output | 1 | Transmit sample valid |
| cdc_tx_data | output | 32 | Transmit sample |
| cdc_tx_ready | input | 1 | Codec accepts the transmit sample |
| cdc_rx_valid | input | 1 | Codec offers a receive sample |
| cdc_rx_data | input | 32 | Receive sample |
| cdc_rx_ready | output | 1 | Block accepts a receive sample |

## Verification
The hardest conditions to reach are the boundaries of the two budgets. Underrun must appear when the transmit FIFO empties in the middle of a sample, and must not appear when the budget and the FIFO content end on the same byte. Overrun behaves the same way against the free space of the receive FIFO. The stimulus preloads the FIFO models with chosen byte counts for each case: exactly on budget, one short, and short partway through a wide sample. It also pre-fills the receive FIFO to leave a chosen amount of room. Random rounds then mix widths, counts, preloads and stalling codec handshakes, and every result is compared with an expected result rebuilt from the counts alone.

// File: rtl/i2s_pk_pkg.sv
package i2s_pk_pkg;

  localparam logic [2:0] FMT_I2S = 3'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_TX, SQ_RX, SQ_DONE} seq_st_t;
  typedef enum logic [1:0] {TX_IDLE, TX_GATHER, TX_SEND} tx_st_t;
  typedef enum logic [1:0] {RX_IDLE, RX_FETCH, RX_SPLIT} rx_st_t;

  // byte budget of one direction for one request
  function automatic int unsigned lane_budget(int unsigned cnt, int unsigned nbytes, logic on);
    return on ? cnt * nbytes : 0;
  endfunction

endpackage

// File: rtl/i2s_pk_tx.sv
module i2s_pk_tx
  import i2s_pk_pkg::*;
#(
  parameter int SAMP_W = 32,
  parameter int BUD_W  = 11,
  parameter int NB_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUD_W-1:0]  bud_in,
  input  logic [NB_W-1:0]   nb_in,
  input  logic              fifo_empty,
  input  logic [7:0]        fifo_rdata,
  output logic              fifo_pop,
  output logic              snk_valid,
  output logic [SAMP_W-1:0] snk_data,
  input  logic              snk_ready,
  output logic              fin,
  output logic              urun
);

  localparam int SH_W = NB_W + 3;

  tx_st_t             st;
  logic [BUD_W-1:0]   bud;
  logic [NB_W-1:0]    nb;
  logic [NB_W-1:0]    idx;
  logic [SAMP_W-1:0]  acc;
  logic [SH_W-1:0]    lane_sh;
  logic               budget_left;
  logic               last_lane;

  assign lane_sh     = {idx, 3'b000};
  assign budget_left = (bud != '0);
  assign last_lane   = (idx + NB_W'(1) == nb) || (bud == BUD_W'(1));

  assign fifo_pop  = (st == TX_GATHER) && budget_left && !fifo_empty;
  assign urun      = (st == TX_GATHER) && budget_left && (idx == '0) && fifo_empty;
  assign fin       = (st == TX_GATHER) && (!budget_left || ((idx == '0) && fifo_empty));
  assign snk_valid = (st == TX_SEND);
  assign snk_data  = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= TX_IDLE;
      bud <= '0;
      nb  <= '0;
      idx <= '0;
      acc <= '0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (start) begin
            bud <= bud_in;
            nb  <= nb_in;
            idx <= '0;
            acc <= '0;
            st  <= TX_GATHER;
          end
        end
        TX_GATHER: begin
          if (fin) begin
            st <= TX_IDLE;
          end else if (fifo_pop) begin
            acc <= acc | (SAMP_W'(fifo_rdata) << lane_sh);
            bud <= bud - BUD_W'(1);
            idx <= idx + NB_W'(1);
            if (last_lane) st <= TX_SEND;
          end else begin
            st <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (snk_ready) begin
            idx <= '0;
            acc <= '0;
            st  <= TX_GATHER;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2s_pk_rx.sv
module i2s_pk_rx
  import i2s_pk_pkg::*;
#(
  parameter int SAMP_W = 32,
  parameter int BUD_W  = 11,
  parameter int NB_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUD_W-1:0]  bud_in,
  input  logic [NB_W-1:0]   nb_in,
  input  logic              fifo_full,
  output logic              fifo_push,
  output logic [7:0]        fifo_wdata,
  input  logic              src_valid,
  input  logic [SAMP_W-1:0] src_data,
  output logic              src_ready,
  output logic              fin,
  output logic              orun
);

  localparam int SH_W = NB_W + 3;

  rx_st_t             st;
  logic [BUD_W-1:0]   bud;
  logic [NB_W-1:0]    nb;
  logic [NB_W-1:0]    idx;
  logic [SAMP_W-1:0]  samp;
  logic [SH_W-1:0]    lane_sh;
  logic               budget_left;

  assign lane_sh     = {idx, 3'b000};
  assign budget_left = (bud != '0);

  assign src_ready  = (st == RX_FETCH) && budget_left && !fifo_full;
  assign orun       = (st == RX_FETCH) && budget_left && fifo_full;
  assign fin        = (st == RX_FETCH) && (!budget_left || fifo_full);
  assign fifo_push  = (st == RX_SPLIT) && (idx != nb) && budget_left && !fifo_full;
  assign fifo_wdata = 8'(samp >> lane_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      bud  <= '0;
      nb   <= '0;
      idx  <= '0;
      samp <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (start) begin
            bud <= bud_in;
            nb  <= nb_in;
            st  <= RX_FETCH;
          end
        end
        RX_FETCH: begin
          if (fin) begin
            st <= RX_IDLE;
          end else if (src_valid) begin
            samp <= src_data;
            idx  <= '0;
            st   <= RX_SPLIT;
          end
        end
        RX_SPLIT: begin
          if (fifo_push) begin
            bud <= bud - BUD_W'(1);
            idx <= idx + NB_W'(1);
          end else begin
            st <= RX_FETCH;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2s_sample_packer.sv
module i2s_sample_packer
  import i2s_pk_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 8,
  localparam int SAMP_W   = 8 * MAX_BYTES,
  localparam int WSEL_W   = $clog2(MAX_BYTES),
  localparam int NB_W     = $clog2(MAX_BYTES + 1),
  localparam int BUD_W    = CNT_W + NB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [2:0]        frame_fmt,
  input  logic              tx_en,
  input  logic              tx_oe,
  input  logic              rx_en,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic              req_valid,
  input  logic [CNT_W-1:0]  req_tx_cnt,
  input  logic [CNT_W-1:0]  req_rx_cnt,
  output logic              req_ready,
  output logic              busy,
  output logic              eval_stb,
  output logic              underrun_set,
  output logic              overrun_set,
  input  logic              txf_empty,
  input  logic [7:0]        txf_rdata,
  output logic              txf_pop,
  input  logic              rxf_full,
  output logic [7:0]        rxf_wdata,
  output logic              rxf_push,
  output logic              cdc_tx_valid,
  output logic [SAMP_W-1:0] cdc_tx_data,
  input  logic              cdc_tx_ready,
  input  logic              cdc_rx_valid,
  input  logic [SAMP_W-1:0] cdc_rx_data,
  output logic              cdc_rx_ready
);

  seq_st_t           sq;
  logic              blk_active;
  logic              req_take;
  logic              tx_start;
  logic              rx_start;
  logic              tx_fin;
  logic              rx_fin;
  logic [NB_W-1:0]   nbytes_now;
  logic [NB_W-1:0]   nb_q;
  logic [BUD_W-1:0]  tx_bud_in;
  logic [BUD_W-1:0]  rx_bud_now;
  logic [BUD_W-1:0]  rx_bud_q;

  assign blk_active = port_en && (frame_fmt == FMT_I2S);
  assign req_ready  = (sq == SQ_IDLE);
  assign req_take   = req_valid && req_ready && blk_active;
  assign nbytes_now = NB_W'(width_sel) + NB_W'(1);
  assign tx_bud_in  = BUD_W'(lane_budget(32'(req_tx_cnt), 32'(nbytes_now), tx_en && tx_oe));
  assign rx_bud_now = BUD_W'(lane_budget(32'(req_rx_cnt), 32'(nbytes_now), rx_en));
  assign tx_start   = req_take;
  assign rx_start   = (sq == SQ_TX) && tx_fin;
  assign busy       = (sq == SQ_TX) || (sq == SQ_RX);
  assign eval_stb   = (sq == SQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq       <= SQ_IDLE;
      nb_q     <= '0;
      rx_bud_q <= '0;
    end else begin
      case (sq)
        SQ_IDLE: begin
          if (req_take) begin
            nb_q     <= nbytes_now;
            rx_bud_q <= rx_bud_now;
            sq       <= SQ_TX;
          end
        end
        SQ_TX:   if (tx_fin) sq <= SQ_RX;
        SQ_RX:   if (rx_fin) sq <= SQ_DONE;
        SQ_DONE: sq <= SQ_IDLE;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  i2s_pk_tx #(.SAMP_W(SAMP_W), .BUD_W(BUD_W), .NB_W(NB_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (tx_start),
    .bud_in     (tx_bud_in),
    .nb_in      (nbytes_now),
    .fifo_empty (txf_empty),
    .fifo_rdata (txf_rdata),
    .fifo_pop   (txf_pop),
    .snk_valid  (cdc_tx_valid),
    .snk_data   (cdc_tx_data),
    .snk_ready  (cdc_tx_ready),
    .fin        (tx_fin),
    .urun       (underrun_set)
  );

  i2s_pk_rx #(.SAMP_W(SAMP_W), .BUD_W(BUD_W), .NB_W(NB_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rx_start),
    .bud_in     (rx_bud_q),
    .nb_in      (nb_q),
    .fifo_full  (rxf_full),
    .fifo_push  (rxf_push),
    .fifo_wdata (rxf_wdata),
    .src_valid  (cdc_rx_valid),
    .src_data   (cdc_rx_data),
    .src_ready  (cdc_rx_ready),
    .fin        (rx_fin),
    .orun       (overrun_set)
  );

endmodule

// File: rtl/i2s_sample_packer_chk.sv
module i2s_sample_packer_chk #(
  parameter int SAMP_W = 32,
  parameter int BUD_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              eval_stb,
  input logic              req_take,
  input logic [BUD_W-1:0]  tx_bud_in,
  input logic              txf_pop,
  input logic              txf_empty,
  input logic              rxf_push,
  input logic              rxf_full,
  input logic              cdc_tx_valid,
  input logic              cdc_tx_ready,
  input logic [SAMP_W-1:0] cdc_tx_data,
  input logic              underrun_set,
  input logic              overrun_set
);

  logic [BUD_W-1:0] pops_seen;
  logic [BUD_W-1:0] pop_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pops_seen <= '0;
      pop_limit <= '0;
    end else if (req_take) begin
      pops_seen <= '0;
      pop_limit <= tx_bud_in;
    end else if (txf_pop) begin
      pops_seen <= pops_seen + BUD_W'(1);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!txf_pop && !rxf_push && !underrun_set && !overrun_set));

  // R3
  pop_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> (pops_seen < pop_limit));

  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> !txf_empty);

  // R5
  urun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_set |-> txf_empty);

  // R6
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> !rxf_full);

  // R7
  orun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_set |-> rxf_full);

  // R8
  eval_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eval_stb);

  // R8
  eval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb |=> !eval_stb);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_tx_valid && !cdc_tx_ready) |=> (cdc_tx_valid && $stable(cdc_tx_data)));

  // R9
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(txf_pop && rxf_push));

endmodule

bind i2s_sample_packer i2s_sample_packer_chk #(.SAMP_W(SAMP_W), .BUD_W(BUD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .eval_stb     (eval_stb),
  .req_take     (req_take),
  .tx_bud_in    (tx_bud_in),
  .txf_pop      (txf_pop),
  .txf_empty    (txf_empty),
  .rxf_push     (rxf_push),
  .rxf_full     (rxf_full),
  .cdc_tx_valid (cdc_tx_valid),
  .cdc_tx_ready (cdc_tx_ready),
  .cdc_tx_data  (cdc_tx_data),
  .underrun_set (underrun_set),
  .overrun_set  (overrun_set)
);

// File: tb/i2s_sample_packer_test.sv
`timescale 1ns/1ps
module i2s_sample_packer_test;

  localparam int RXD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        port_en = 1'b0;
  logic [2:0]  frame_fmt = 3'd0;
  logic        tx_en = 1'b0, tx_oe = 1'b0, rx_en = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_tx_cnt = 8'd0, req_rx_cnt = 8'd0;
  logic        req_ready, busy, eval_stb, underrun_set, overrun_set;
  logic        txf_empty = 1'b1;
  logic [7:0]  txf_rdata = 8'd0;
  logic        txf_pop;
  logic        rxf_full = 1'b0;
  logic [7:0]  rxf_wdata;
  logic        rxf_push;
  logic        cdc_tx_valid;
  logic [31:0] cdc_tx_data;
  logic        cdc_tx_ready = 1'b0;
  logic        cdc_rx_valid = 1'b0;
  logic [31:0] cdc_rx_data = 32'd0;
  logic        cdc_rx_ready;

  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  logic [31:0] srcq[$];
  logic [31:0] capq[$];
  logic [7:0]  txsave[$];
  logic [31:0] srcsave[$];

  int urun_n, orun_n, eval_n, busy_n;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  i2s_sample_packer uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .frame_fmt(frame_fmt),
    .tx_en(tx_en), .tx_oe(tx_oe), .rx_en(rx_en), .width_sel(width_sel),
    .req_valid(req_valid), .req_tx_cnt(req_tx_cnt), .req_rx_cnt(req_rx_cnt),
    .req_ready(req_ready), .busy(busy), .eval_stb(eval_stb),
    .underrun_set(underrun_set), .overrun_set(overrun_set),
    .txf_empty(txf_empty), .txf_rdata(txf_rdata), .txf_pop(txf_pop),
    .rxf_full(rxf_full), .rxf_wdata(rxf_wdata), .rxf_push(rxf_push),
    .cdc_tx_valid(cdc_tx_valid), .cdc_tx_data(cdc_tx_data), .cdc_tx_ready(cdc_tx_ready),
    .cdc_rx_valid(cdc_rx_valid), .cdc_rx_data(cdc_rx_data), .cdc_rx_ready(cdc_rx_ready)
  );

  // FIFO and codec models: registered views, updated with nonblocking assigns
  always @(posedge clk) begin
    if (txf_pop && txq.size() > 0) void'(txq.pop_front());
    if (rxf_push) rxq.push_back(rxf_wdata);
    if (cdc_tx_valid && cdc_tx_ready) capq.push_back(cdc_tx_data);
    if (cdc_rx_valid && cdc_rx_ready && srcq.size() > 0) void'(srcq.pop_front());
    if (underrun_set) urun_n++;
    if (overrun_set) orun_n++;
    if (eval_stb) eval_n++;
    if (busy) busy_n++;
    txf_empty    <= (txq.size() == 0);
    txf_rdata    <= (txq.size() > 0) ? txq[0] : 8'd0;
    rxf_full     <= (rxq.size() >= RXD);
    cdc_tx_ready <= (($urandom % 4) != 0);
    cdc_rx_valid <= (srcq.size() > 0) && (($urandom % 3) != 0);
    cdc_rx_data  <= (srcq.size() > 0) ? srcq[0] : 32'd0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // expected transmit sample s: bytes taken in order, LSB first, zero padded
  function automatic logic [31:0] exp_tx_word(int s, int nb, int popped);
    logic [31:0] w = 32'd0;
    for (int i = 0; i < nb; i++) begin
      int k = s * nb + i;
      if (k < popped) w = w | (32'(txsave[k]) << (8 * i));
    end
    return w;
  endfunction

  function automatic logic [7:0] exp_rx_byte(int k, int nb);
    return 8'(srcsave[k / nb] >> (8 * (k % nb)));
  endfunction

  task automatic prepare(input int txload, input int prefill, input int nsrc);
    @(negedge clk);
    txq.delete(); txsave.delete(); rxq.delete(); srcq.delete(); srcsave.delete(); capq.delete();
    for (int i = 0; i < txload; i++) begin
      logic [7:0] b = 8'($urandom);
      txq.push_back(b); txsave.push_back(b);
    end
    for (int i = 0; i < prefill; i++) rxq.push_back(8'hEE);
    for (int i = 0; i < nsrc; i++) begin
      logic [31:0] w = $urandom;
      srcq.push_back(w); srcsave.push_back(w);
    end
    urun_n = 0; orun_n = 0; eval_n = 0; busy_n = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic issue(input int tcnt, input int rcnt);
    req_tx_cnt = 8'(tcnt); req_rx_cnt = 8'(rcnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_xfer(input int wsel, input int tcnt, input int rcnt,
                          input int txload, input int prefill, input string tag);
    int nb, txb, tpop, nsamp, rxb, free, rpush, waited;
    bit okw;
    width_sel = 2'(wsel);
    prepare(txload, prefill, rcnt);
    issue(tcnt, rcnt);
    waited = 0;
    while (eval_n == 0 && waited < 4000) begin
      @(negedge clk); waited++;
    end
    @(negedge clk); @(negedge clk);
    chk(waited < 4000, "R8", {tag, " transfer finished"}, waited, 0);
    nb    = wsel + 1;
    txb   = (tx_en && tx_oe) ? tcnt * nb : 0;
    tpop  = imin(txb, txload);
    nsamp = (tpop + nb - 1) / nb;
    rxb   = rx_en ? rcnt * nb : 0;
    free  = RXD - prefill;
    rpush = imin(rxb, free);
    // R3: bytes consumed bounded by budget
    chk(txq.size() == txload - tpop, "R3", {tag, " tx bytes left"}, txq.size(), txload - tpop);
    // R4: sample count and packing
    chk(capq.size() == nsamp, "R4", {tag, " tx sample count"}, capq.size(), nsamp);
    okw = (capq.size() == nsamp);
    for (int s = 0; s < nsamp && okw; s++)
      if (capq[s] !== exp_tx_word(s, nb, tpop)) begin
        okw = 0;
        chk(0, "R4", {tag, " tx sample value"}, int'(capq[s]), int'(exp_tx_word(s, nb, tpop)));
      end
    if (okw) chk(1, "R4", {tag, " tx samples"}, 0, 0);
    // R5: underrun
    chk(urun_n == (txb > txload ? 1 : 0), "R5", {tag, " underrun pulses"}, urun_n, (txb > txload ? 1 : 0));
    // R6: receive bytes
    chk(rxq.size() == prefill + rpush, "R6", {tag, " rx fifo level"}, rxq.size(), prefill + rpush);
    okw = (rxq.size() == prefill + rpush);
    for (int k = 0; k < rpush && okw; k++)
      if (rxq[prefill + k] !== exp_rx_byte(k, nb)) begin
        okw = 0;
        chk(0, "R6", {tag, " rx byte"}, int'(rxq[prefill + k]), int'(exp_rx_byte(k, nb)));
      end
    if (okw) chk(1, "R6", {tag, " rx bytes"}, 0, 0);
    // R7: overrun
    chk(orun_n == (rxb > free ? 1 : 0), "R7", {tag, " overrun pulses"}, orun_n, (rxb > free ? 1 : 0));
    // R8: busy window and single strobe
    chk(eval_n == 1, "R8", {tag, " eval strobes"}, eval_n, 1);
    chk(busy_n > 0 && busy == 1'b0 && req_ready == 1'b1, "R8", {tag, " busy window"}, busy_n, 1);
  endtask

  // R1: request under an inactive setting is dropped
  task automatic run_idle(input string tag);
    width_sel = 2'd1;
    prepare(6, 2, 4);
    issue(3, 3);
    repeat (12) @(negedge clk);
    chk(busy_n == 0 && eval_n == 0, "R1", {tag, " no busy or strobe"}, busy_n + eval_n, 0);
    chk(txq.size() == 6 && capq.size() == 0, "R1", {tag, " tx untouched"}, txq.size(), 6);
    chk(rxq.size() == 2 && urun_n == 0 && orun_n == 0, "R1", {tag, " rx untouched"}, rxq.size(), 2);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk(busy == 1'b0 && eval_stb == 1'b0 && req_ready == 1'b1, "R8", "reset idle", busy, 0);
    chk(txf_pop == 1'b0 && rxf_push == 1'b0 && cdc_tx_valid == 1'b0, "R1", "reset quiet", txf_pop, 0);

    port_en = 1; frame_fmt = 3'd3; tx_en = 1; tx_oe = 1; rx_en = 1;
    // R3 / R5: exact budget, no underrun
    run_xfer(1, 3, 2, 6, 0, "exact_tx");
    // R4 / R5: underrun inside a 4-byte sample
    run_xfer(3, 2, 1, 5, 0, "partial_tx");
    // R7: overrun on a nearly full receive FIFO
    run_xfer(0, 1, 10, 1, 12, "overrun");
    // R7: budget ends exactly at full
    run_xfer(1, 0, 3, 0, 10, "exact_rx");
    // R3: wide samples
    run_xfer(2, 4, 4, 20, 0, "wide");
    // R3: zero counts
    run_xfer(3, 0, 0, 4, 0, "zero");
    // R2: output enable off, empty FIFO, no underrun
    tx_oe = 0;
    run_xfer(1, 5, 1, 0, 0, "tx_oe_off");
    tx_oe = 1; tx_en = 0;
    run_xfer(0, 5, 1, 3, 0, "tx_en_off");
    tx_en = 1; rx_en = 0;
    // R6: receive off
    run_xfer(2, 1, 6, 3, 15, "rx_off");
    rx_en = 1;
    // R1: wrong format, then port disabled
    frame_fmt = 3'd1;
    run_idle("fmt_spi");
    frame_fmt = 3'd3; port_en = 0;
    run_idle("port_off");
    port_en = 1;

    for (int r = 0; r < 40; r++) begin
      tx_en = ($urandom % 6) != 0;
      tx_oe = ($urandom % 6) != 0;
      rx_en = ($urandom % 6) != 0;
      run_xfer($urandom % 4, $urandom % 9, $urandom % 9, $urandom % 25, $urandom % 17, "random");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule